// File: doc/BRIEF.md
# CEC Frame Transmitter

This block sends one frame on a single-wire, open-drain consumer-electronics control bus. Software fills a byte buffer of up to sixteen entries, then pulses `start` with a length and a few options. The block first waits until the bus has stayed released for a selectable number of bit periods. It then optionally sends a start bit, and sends each byte most significant bit first. Each byte is followed by an end-of-message slot and an acknowledge slot.

All timing comes from a tick made by dividing the system clock by `cfg_div`, which software sets so that one tick is 0.1 ms. The block reads the bus back through a two-stage synchronizer. It uses that reading to see the acknowledge from followers and to detect when another initiator is overriding one of its released bits. At the end of a frame it raises sticky status flags, which software clears by writing ones.

Top module: `cec_frame_tx`

## Requirements
- R1: All bus timing is counted in ticks, and one tick occurs every `cfg_div` clock cycles. A value of zero behaves as one.
- R2: Before the first bit, the block waits until the synchronized line has read high for N whole 24-tick bit periods without a break. N is 7 for `gap_sel`=0 or 3, 5 for `gap_sel`=1 and 3 for `gap_sel`=2. Any low reading restarts the count.
- R3: With `auto_som`=1, the frame begins with a start bit that holds the line low for 37 ticks in a 45-tick period. With `auto_som`=0, no start bit is sent.
- R4: Byte k of the frame is buffer entry k, sent most significant bit first. A 0 bit is driven low for 15 ticks and a 1 bit for 6 ticks, and every bit period is 24 ticks.
- R5: With `auto_eom`=1, the slot after each byte carries 1 after the last byte and 0 after every other byte. With `auto_eom`=0, that slot always carries 0.
- R6: The block sends each acknowledge slot as a 1 and reads the line 10 ticks into the slot, where low means acknowledged. `stat_ack` is set at completion only if every acknowledge slot that was sent read low.
- R7: With `stop_on_nack`=1, the frame ends after the acknowledge slot of the first byte that was not acknowledged. `stat_done` is set and `stat_ack` stays clear. With `stop_on_nack`=0, all bytes are sent.
- R8: If the line reads low 10 ticks into a data or end-of-message slot in which the block sent a 1, the block releases the line at once. It sends nothing more and sets `stat_arb` and `stat_done`.
- R9: A start with a length of 0 or above 16 causes no bus activity, does not set `busy`, and sets `stat_err` and `stat_done`.
- R10: The status flags hold until cleared. Writing a 1 on `stat_clr` bit 0/1/2/3 clears done/ack/arb/err respectively and leaves the other flags unchanged.
- R11: A `start` pulse while `busy` is high is ignored. The running frame keeps the length and options it latched when it began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 16 | Clock cycles per 0.1 ms tick |
| buf_we | input | 1 | Write enable for the byte buffer |
| buf_addr | input | 4 | Buffer entry to write |
| buf_wdata | input | 8 | Byte written to the buffer |
| start | input | 1 | Single-cycle request to send a frame |
| start_len | input | 5 | Number of bytes to send, latched with start |
| auto_som | input | 1 | Send a start bit before the first byte |
| auto_eom | input | 1 | Mark the last byte in its end-of-message slot |
| stop_on_nack | input | 1 | End the frame at the first missing acknowledge |
| gap_sel | input | 2 | Idle-time selection (0/3: 7, 1: 5, 2: 3 bit periods) |
| stat_clr | input | 4 | Write-one-to-clear for done, ack, arb, err |
| cec_in | input | 1 | Bus level read back from the pad |
| cec_drive_low | output | 1 | Enables the open-drain pull-down |
| busy | output | 1 | A frame is waiting or being sent |
| stat_done | output | 1 | Sticky: a frame finished or was refused |
| stat_ack | output | 1 | Sticky: every byte was acknowledged |
| stat_arb | output | 1 | Sticky: arbitration was lost |
| stat_err | output | 1 | Sticky: start had an invalid length |

## Verification
The assertions check on every cycle a set of properties. The pull-down is only enabled while a frame is in progress, and no pull-down ever lasts longer than a start bit. An arbitration loss or a refused start leaves the line released and the engine idle. Acknowledge and done are reported together, and the sticky flags hold until they are cleared. Only the bench scenarios can show the rest: exact pulse widths and periods for given byte values, the idle wait for each selection and its restart, the early stop on a missing acknowledge, the release at the contested bit, and that a second start is ignored. They do this by replaying the frame through a behavioural model of the bus with a scripted follower.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_SOM  = 2'd2,
    ST_BIT  = 2'd3
  } tx_state_e;

  // bit 0 done, bit 1 ack, bit 2 arb, bit 3 err (matches stat_clr)
  typedef struct packed {
    logic err;
    logic arb;
    logic ack;
    logic done;
  } tx_flags_t;

endpackage

// File: rtl/cec_tick_gen.sv
module cec_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] last;

  assign last = (div == '0) ? '0 : div - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= last) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_ALIGN: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt == '0)); // R1

endmodule

// File: rtl/cec_tx_buf.sv
module cec_tx_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/cec_tx_engine.sv
module cec_tx_engine
  import cec_tx_pkg::*;
#(
  parameter int NBYTES    = 16,
  parameter int AW        = 4,
  parameter int LEN_W     = 5,
  parameter int T_SOM_LOW = 37,
  parameter int T_SOM     = 45,
  parameter int T_ZERO    = 15,
  parameter int T_ONE     = 6,
  parameter int T_BIT     = 24,
  parameter int T_SAMPLE  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             line,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             auto_som,
  input  logic             auto_eom,
  input  logic             stop_on_nack,
  input  logic [1:0]       gap_sel,
  input  logic [7:0]       byte_data,
  output logic [AW-1:0]    byte_idx,
  output logic             drive_low,
  output logic             busy,
  output logic             ev_done,
  output logic             ev_ack,
  output logic             ev_arb,
  output logic             ev_err
);

  localparam int PH_W   = $clog2(T_SOM + 1);
  localparam int GAP_W  = $clog2(7 * T_BIT + 1);
  localparam int SLOT_W = 4;
  localparam logic [SLOT_W-1:0] SLOT_EOM = SLOT_W'(8);
  localparam logic [SLOT_W-1:0] SLOT_ACK = SLOT_W'(9);
  localparam logic [LEN_W-1:0]  MAX_LEN  = LEN_W'(NBYTES);

  tx_state_e          st;
  logic [PH_W-1:0]    ph, ph_nx, low_len;
  logic [SLOT_W-1:0]  slot;
  logic [AW-1:0]      last_idx;
  logic [GAP_W-1:0]   gap_cnt, gap_need;
  logic               som_q, eom_q, stop_q;
  logic               all_ack, ack_now, bit_val;

  function automatic logic [GAP_W-1:0] gap_of(input logic [1:0] sel);
    case (sel)
      2'd1:    return GAP_W'(5 * T_BIT);
      2'd2:    return GAP_W'(3 * T_BIT);
      default: return GAP_W'(7 * T_BIT);
    endcase
  endfunction

  assign ph_nx = ph + 1'b1;
  assign busy  = (st != ST_IDLE);

  always_comb begin
    if (slot < SLOT_EOM)       bit_val = byte_data[3'd7 - slot[2:0]];
    else if (slot == SLOT_EOM) bit_val = eom_q && (byte_idx == last_idx);
    else                       bit_val = 1'b1;
    low_len = bit_val ? PH_W'(T_ONE) : PH_W'(T_ZERO);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      drive_low <= 1'b0;
      ph        <= '0;
      slot      <= '0;
      byte_idx  <= '0;
      last_idx  <= '0;
      gap_cnt   <= '0;
      gap_need  <= '0;
      som_q     <= 1'b0;
      eom_q     <= 1'b0;
      stop_q    <= 1'b0;
      all_ack   <= 1'b0;
      ack_now   <= 1'b0;
      ev_done   <= 1'b0;
      ev_ack    <= 1'b0;
      ev_arb    <= 1'b0;
      ev_err    <= 1'b0;
    end else begin
      ev_done <= 1'b0;
      ev_ack  <= 1'b0;
      ev_arb  <= 1'b0;
      ev_err  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (len == '0 || len > MAX_LEN) begin
              ev_err  <= 1'b1;
              ev_done <= 1'b1;
            end else begin
              st       <= ST_WAIT;
              gap_cnt  <= '0;
              gap_need <= gap_of(gap_sel);
              som_q    <= auto_som;
              eom_q    <= auto_eom;
              stop_q   <= stop_on_nack;
              last_idx <= AW'(len - 1'b1);
              byte_idx <= '0;
              all_ack  <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (!line) begin
            gap_cnt <= '0;
          end else if (tick) begin
            if (gap_cnt + 1'b1 == gap_need) begin
              drive_low <= 1'b1;
              ph        <= '0;
              slot      <= '0;
              st        <= som_q ? ST_SOM : ST_BIT;
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        ST_SOM: begin
          if (tick) begin
            if (ph_nx == PH_W'(T_SOM_LOW)) drive_low <= 1'b0;
            if (ph_nx == PH_W'(T_SOM)) begin
              ph        <= '0;
              drive_low <= 1'b1;
              st        <= ST_BIT;
            end else begin
              ph <= ph_nx;
            end
          end
        end
        ST_BIT: begin
          if (tick) begin
            if (ph_nx == low_len) drive_low <= 1'b0;
            if (ph_nx == PH_W'(T_SAMPLE)) begin
              if (slot == SLOT_ACK) begin
                ack_now <= !line;
              end else if (bit_val && !line) begin
                drive_low <= 1'b0;
                st        <= ST_IDLE;
                ev_arb    <= 1'b1;
                ev_done   <= 1'b1;
              end
            end
            if (ph_nx == PH_W'(T_BIT)) begin
              ph <= '0;
              if (slot == SLOT_ACK) begin
                if (byte_idx == last_idx || (stop_q && !ack_now)) begin
                  st      <= ST_IDLE;
                  ev_done <= 1'b1;
                  ev_ack  <= all_ack && ack_now;
                end else begin
                  all_ack   <= all_ack && ack_now;
                  byte_idx  <= byte_idx + 1'b1;
                  slot      <= '0;
                  drive_low <= 1'b1;
                end
              end else begin
                slot      <= slot + 1'b1;
                drive_low <= 1'b1;
              end
            end else begin
              ph <= ph_nx;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // length of the current low pulse, in ticks, for the bound check
  logic [PH_W-1:0] low_run;
  always_ff @(posedge clk) begin
    if (rst || !drive_low) low_run <= '0;
    else if (tick)         low_run <= low_run + 1'b1;
  end

  AST_LOW_BOUND: assert property (@(posedge clk) disable iff (rst)
    low_run <= PH_W'(T_SOM_LOW)); // R3
  AST_DRIVE_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    drive_low |-> busy); // R4
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ev_arb |-> (!drive_low && !busy)); // R8
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    ev_err |-> (!drive_low && !busy)); // R9
  AST_ACK_AT_END: assert property (@(posedge clk) disable iff (rst)
    ev_ack |-> ev_done); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ev_done |=> !ev_done); // R7

endmodule

// File: rtl/cec_frame_tx.sv
module cec_frame_tx
  import cec_tx_pkg::*;
#(
  parameter int DIV_W     = 16,
  parameter int NBYTES    = 16,
  parameter int LEN_W     = 5,
  parameter int T_SOM_LOW = 37,
  parameter int T_SOM     = 45,
  parameter int T_ZERO    = 15,
  parameter int T_ONE     = 6,
  parameter int T_BIT     = 24,
  parameter int T_SAMPLE  = 10,
  localparam int AW       = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             buf_we,
  input  logic [AW-1:0]    buf_addr,
  input  logic [7:0]       buf_wdata,
  input  logic             start,
  input  logic [LEN_W-1:0] start_len,
  input  logic             auto_som,
  input  logic             auto_eom,
  input  logic             stop_on_nack,
  input  logic [1:0]       gap_sel,
  input  logic [3:0]       stat_clr,
  input  logic             cec_in,
  output logic             cec_drive_low,
  output logic             busy,
  output logic             stat_done,
  output logic             stat_ack,
  output logic             stat_arb,
  output logic             stat_err
);

  logic       tick;
  logic [1:0] sync_q;
  logic       line;
  logic [AW-1:0] rd_idx;
  logic [7:0] rd_byte;
  logic       ev_done, ev_ack, ev_arb, ev_err;
  tx_flags_t  flags_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], cec_in};
  end
  assign line = sync_q[1];

  cec_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .div  (cfg_div),
    .tick (tick)
  );

  cec_tx_buf #(.DEPTH(NBYTES), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (rd_idx),
    .rdata (rd_byte)
  );

  cec_tx_engine #(
    .NBYTES(NBYTES), .AW(AW), .LEN_W(LEN_W),
    .T_SOM_LOW(T_SOM_LOW), .T_SOM(T_SOM), .T_ZERO(T_ZERO),
    .T_ONE(T_ONE), .T_BIT(T_BIT), .T_SAMPLE(T_SAMPLE)
  ) u_eng (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .line         (line),
    .start        (start),
    .len          (start_len),
    .auto_som     (auto_som),
    .auto_eom     (auto_eom),
    .stop_on_nack (stop_on_nack),
    .gap_sel      (gap_sel),
    .byte_data    (rd_byte),
    .byte_idx     (rd_idx),
    .drive_low    (cec_drive_low),
    .busy         (busy),
    .ev_done      (ev_done),
    .ev_ack       (ev_ack),
    .ev_arb       (ev_arb),
    .ev_err       (ev_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else begin
      flags_q.done <= (flags_q.done & ~stat_clr[0]) | ev_done;
      flags_q.ack  <= (flags_q.ack  & ~stat_clr[1]) | ev_ack;
      flags_q.arb  <= (flags_q.arb  & ~stat_clr[2]) | ev_arb;
      flags_q.err  <= (flags_q.err  & ~stat_clr[3]) | ev_err;
    end
  end

  assign stat_done = flags_q.done;
  assign stat_ack  = flags_q.ack;
  assign stat_arb  = flags_q.arb;
  assign stat_err  = flags_q.err;

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_done && !stat_clr[0]) |=> stat_done); // R10
  AST_ARB_STICKY: assert property (@(posedge clk) disable iff (rst)
    (stat_arb && !stat_clr[2]) |=> stat_arb); // R10

endmodule

// File: tb/tb_cec_frame_tx.sv
module tb_cec_frame_tx;

  localparam int NB = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cfg_div = 16'd4;
  logic        buf_we = 1'b0;
  logic [3:0]  buf_addr = '0;
  logic [7:0]  buf_wdata = '0;
  logic        start = 1'b0;
  logic [4:0]  start_len = '0;
  logic        auto_som = 1'b0, auto_eom = 1'b0, stop_on_nack = 1'b0;
  logic [1:0]  gap_sel = '0;
  logic [3:0]  stat_clr = '0;
  logic        cec_in;
  logic        cec_drive_low, busy, stat_done, stat_ack, stat_arb, stat_err;
  logic        fol_low = 1'b0;
  logic        ext_low = 1'b0;

  always #4 clk = ~clk;

  assign cec_in = ~(cec_drive_low | fol_low | ext_low);

  cec_frame_tx dut (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .start(start),
    .start_len(start_len), .auto_som(auto_som), .auto_eom(auto_eom),
    .stop_on_nack(stop_on_nack), .gap_sel(gap_sel), .stat_clr(stat_clr),
    .cec_in(cec_in), .cec_drive_low(cec_drive_low), .busy(busy),
    .stat_done(stat_done), .stat_ack(stat_ack), .stat_arb(stat_arb),
    .stat_err(stat_err)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, cur_div = 4;
  int fall_q[$], rise_q[$], exp_low_q[$], exp_per_q[$];
  int fol_plan[int];
  int pulse_no = 0, fol_left = 0;
  logic drv_prev = 1'b0;
  logic [7:0] fbytes [NB];
  bit e_ack, e_arb;

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor and scripted follower
  always @(negedge clk) begin
    if (cec_drive_low && !drv_prev) begin
      fall_q.push_back(cyc);
      if (fol_plan.exists(pulse_no)) fol_left = fol_plan[pulse_no] * cur_div;
      pulse_no++;
    end
    if (!cec_drive_low && drv_prev) rise_q.push_back(cyc);
    drv_prev = cec_drive_low;
    if (fol_left > 0) begin fol_low = 1'b1; fol_left--; end
    else fol_low = 1'b0;
  end

  always @(posedge clk) begin
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rng(string req, int act, int lo, int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  // behavioural model of the bus sequence in ticks
  task automatic model(int len, bit som, bit eom, bit stop);
    int p = 0;
    bit acked, v;
    exp_low_q.delete(); exp_per_q.delete();
    e_ack = 1'b1; e_arb = 1'b0;
    if (som) begin exp_low_q.push_back(37); exp_per_q.push_back(45); p++; end
    for (int b = 0; b < len; b++) begin
      acked = 1'b0;
      for (int s = 0; s < 10; s++) begin
        if (s < 8)       v = fbytes[b][7-s];
        else if (s == 8) v = eom && (b == len - 1);
        else             v = 1'b1;
        exp_low_q.push_back(v ? 6 : 15);
        exp_per_q.push_back(24);
        if (s < 9 && v && fol_plan.exists(p)) begin
          e_arb = 1'b1; e_ack = 1'b0; return;
        end
        if (s == 9) acked = fol_plan.exists(p);
        p++;
      end
      if (!acked) begin
        e_ack = 1'b0;
        if (stop) return;
      end
    end
  endtask

  task automatic clear_flags(logic [3:0] v);
    @(negedge clk); stat_clr = v;
    @(negedge clk); stat_clr = '0;
  endtask

  task automatic plan_acks(int len, bit som, int skip);
    fol_plan.delete();
    for (int b = 0; b < len; b++)
      if (b != skip) fol_plan[(som ? 1 : 0) + b * 10 + 9] = 15;
  endtask

  task automatic run(string req, int len, bit som, bit eom, bit stop,
                     logic [1:0] gsel, int nbits, bit poke, bit glitch);
    int t0, guard, n;
    for (int i = 0; i < NB; i++) begin
      @(negedge clk); buf_we = 1'b1; buf_addr = 4'(i); buf_wdata = fbytes[i];
    end
    @(negedge clk); buf_we = 1'b0;
    fall_q.delete(); rise_q.delete(); pulse_no = 0;
    start = 1'b1; start_len = 5'(len); auto_som = som; auto_eom = eom;
    stop_on_nack = stop; gap_sel = gsel; t0 = cyc;
    @(negedge clk); start = 1'b0;
    if (glitch) begin
      repeat (60) @(negedge clk);
      ext_low = 1'b1;
      repeat (20) @(negedge clk);
      ext_low = 1'b0; t0 = cyc;
    end
    if (poke) begin
      repeat (40) @(negedge clk);
      start = 1'b1; start_len = 5'd1; auto_som = ~som; stop_on_nack = ~stop;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 100000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    model(len, som, eom, stop);
    chk({req, " pulse count"}, fall_q.size(), exp_low_q.size());
    n = (fall_q.size() < exp_low_q.size()) ? fall_q.size() : exp_low_q.size();
    if (rise_q.size() < n) n = rise_q.size();
    for (int i = 0; i < n; i++) begin
      chk({req, " R1 R4 low time"}, rise_q[i] - fall_q[i], exp_low_q[i] * cur_div);
      if (i + 1 < n)
        chk({req, " R4 period"}, fall_q[i+1] - fall_q[i], exp_per_q[i] * cur_div);
    end
    if (fall_q.size() > 0)
      chk_rng({req, " R2 idle wait"}, fall_q[0] - t0,
              (nbits * 24 - 1) * cur_div + 1, nbits * 24 * cur_div + 4);
    chk({req, " done flag"}, int'(stat_done), 1);
    chk({req, " R6 ack flag"}, int'(stat_ack), int'(e_ack));
    chk({req, " R8 arb flag"}, int'(stat_arb), int'(e_arb));
    chk({req, " err flag"}, int'(stat_err), 0);
  endtask

  task automatic run_bad(int len);
    fall_q.delete(); rise_q.delete();
    @(negedge clk); start = 1'b1; start_len = 5'(len);
    @(negedge clk); start = 1'b0;
    chk("R9 busy stays low", int'(busy), 0);
    repeat (400) @(negedge clk);
    chk("R9 no bus activity", fall_q.size(), 0);
    chk("R9 err flag", int'(stat_err), 1);
    chk("R9 done flag", int'(stat_done), 1);
    clear_flags(4'hF);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset drive", int'(cec_drive_low), 0);
    chk("reset busy", int'(busy), 0);
    chk("reset flags", int'({stat_done, stat_ack, stat_arb, stat_err}), 0);

    // two bytes, all acknowledged, second start ignored (R11), gap 5 (R2)
    fbytes[0] = 8'hA5; fbytes[1] = 8'h3C;
    for (int i = 2; i < NB; i++) fbytes[i] = 8'h00;
    plan_acks(2, 1'b1, -1);
    run("R3 R5 R11", 2, 1'b1, 1'b1, 1'b1, 2'd1, 5, 1'b1, 1'b0);
    // R10 partial clear keeps the others
    clear_flags(4'b0010);
    @(negedge clk);
    chk("R10 ack cleared", int'(stat_ack), 0);
    chk("R10 done kept", int'(stat_done), 1);
    clear_flags(4'b0001);
    @(negedge clk);
    chk("R10 done cleared", int'(stat_done), 0);

    // sixteen bytes, gap 7
    for (int i = 0; i < NB; i++) fbytes[i] = 8'(i * 17 + 3);
    plan_acks(16, 1'b1, -1);
    run("R4 full buffer", 16, 1'b1, 1'b1, 1'b0, 2'd0, 7, 1'b0, 1'b0);
    clear_flags(4'hF);

    // missing acknowledge on byte 1, stopping (R7)
    fbytes[0] = 8'h10; fbytes[1] = 8'hFF; fbytes[2] = 8'h81;
    plan_acks(3, 1'b1, 1);
    run("R7 stop", 3, 1'b1, 1'b1, 1'b1, 2'd2, 3, 1'b0, 1'b0);
    clear_flags(4'hF);
    run("R7 continue", 3, 1'b1, 1'b1, 1'b0, 2'd2, 3, 1'b0, 1'b0);
    clear_flags(4'hF);

    // arbitration: another initiator drives 0 on bit 6 of byte 0 (R8)
    fbytes[0] = 8'h40;
    fol_plan.delete(); fol_plan[2] = 15;
    run("R8 arbitration", 2, 1'b1, 1'b1, 1'b0, 2'd1, 5, 1'b0, 1'b0);
    clear_flags(4'hF);

    // no start bit, no end marking, other divisor (R1 R3 R5)
    cur_div = 3; cfg_div = 16'd3;
    fbytes[0] = 8'h5A; fbytes[1] = 8'hC3;
    plan_acks(2, 1'b0, -1);
    run("R1 R3 R5 plain", 2, 1'b0, 1'b0, 1'b0, 2'd2, 3, 1'b0, 1'b0);
    clear_flags(4'hF);
    cur_div = 4; cfg_div = 16'd4;

    // idle count restarts after a low line (R2), gap_sel 3 means 7
    plan_acks(1, 1'b1, -1);
    run("R2 restart", 1, 1'b1, 1'b1, 1'b0, 2'd3, 7, 1'b0, 1'b1);
    clear_flags(4'hF);

    run_bad(0);
    run_bad(17);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule